// File: doc/BRIEF.md
# Filtered Capture Input Unit

This block time-stamps external pulse edges. Each of its capture channels takes an asynchronous input pin and brings it into the clock domain with a two-flop synchronizer. A majority-vote filter then rejects short noise pulses, and when the selected edge appears the channel stores the value of a shared free-running counter. The counter gives a common time base, so software can measure event intervals and pulse widths by subtracting captured values.

Each channel samples its synchronized input at a programmable rate of one sample every 1, 2, 4 or 8 clocks. The filter keeps the last four samples. It moves to a new level only when at least three of the four samples agree. A bypass setting feeds the synchronized input straight to the edge detector instead. A capture raises a sticky flag that drives an interrupt line. A capture that arrives while the flag is still set also marks an overrun. The counter raises its own sticky flag each time it wraps.

Software reaches the block through a simple port: a write strobe with address and data, and a combinational read selected by a separate address.

Top module: `cap_unit`

## Requirements
- R1: The channels are independent: stimulus, configuration or clearing on one channel never changes another channel's flag, overrun bit or captured value.
- R2: On a qualified edge the channel stores the counter value seen in the cycle in which the edge is detected. In bypass mode, with the pin changing just after clock edge 0, the flag is set after edge 3 and the stored value is the counter reading taken before edge 1 plus 2.
- R3: With the filter on, the filtered level becomes 1 only when at least three of the last four samples are 1, and becomes 0 only when at least three are 0. With exactly two of each it keeps its previous level, so a pulse that covers two samples is rejected and one that covers three is accepted.
- R4: Control bits [1:0] select one sample every 1, 2, 4 or 8 clocks (codes 0 to 3). At a sample every clock, a held edge is captured as the counter reading plus 5. At a sample every S clocks, it is captured somewhere between reading + 3 + 2S and reading + 2 + 3S.
- R5: Control bit 2 set (bypass) sends the synchronized input to the edge detector without the filter, and even a two-clock pulse is seen.
- R6: Control bits [4:3] select the edge: 00 no capture, 01 rising, 10 falling, 11 both. An edge that is not selected leaves the flag and the captured value unchanged.
- R7: A capture sets the channel flag (status bit i, output cap_irq[i]). The flag stays set until a write to the status address with bit i at 1. If the clear and a new capture fall in the same cycle, the capture wins.
- R8: A capture while the flag is already set sets the overrun bit (status bit NCH+i), which is cleared by writing 1 to that bit. The newer counter value replaces the stored one.
- R9: The counter advances by one every clock and wraps from all ones to zero. The wrap sets status bit 2*NCH and wrap_irq, which stay set until cleared by writing 1 to that bit.
- R10: After reset the counter, all captured values, flags, overrun bits and the wrap flag are zero.
- R11: Read addresses: i gives channel i's control bits, NCH+i its captured value, 2*NCH the status word, 2*NCH+1 the counter. Writes to i load control bits, and writes to 2*NCH clear status bits. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | NCH | Asynchronous capture inputs, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | WD_W | Write data (control bits or status clear mask) |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | CNT_W | Combinational read data |
| cap_irq | output | NCH | Per-channel capture flags |
| wrap_irq | output | 1 | Counter wrap flag |

## Verification
The hardest case to reach from the ports is the filter's hold band. The four-sample window must contain exactly two highs and two lows at a sampling instant, and at slow sample rates the phase of the free-running sample divider is not visible from outside. The stimulus holds pulses for whole multiples of the sample period, so a pulse of two periods is sure to land on exactly two samples whatever the phase. Exact timing is checked only at a sample every clock. At the slower rates the captured value is checked against the window that the unknown phase allows. The counter wrap is reached by polling the counter until it reads all ones and then checking the next cycle.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int RATE_W = 2;
    localparam int DIV_W  = (1 << RATE_W) - 1;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_e;

    typedef struct packed {
        edge_e             edge_sel;
        logic              bypass;
        logic [RATE_W-1:0] rate;
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);

    function automatic logic [DIV_W-1:0] rate_limit(input logic [RATE_W-1:0] r);
        logic [DIV_W:0] one;
        logic [DIV_W:0] span;
        one  = 1;
        span = (one << r) - 1'b1;
        return span[DIV_W-1:0];
    endfunction

    function automatic logic [2:0] ones4(input logic [3:0] w);
        return {2'b00, w[0]} + {2'b00, w[1]} + {2'b00, w[2]} + {2'b00, w[3]};
    endfunction

endpackage

// File: rtl/cap_free_counter.sv
module cap_free_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] cnt_o,
    output logic         at_top_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o    = cnt_q;
    assign at_top_o = &cnt_q;

    assert_wrap_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '1) |=> (cnt_q == '0));

    assert_step_one_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/cap_input_filter.sv
module cap_input_filter
    import cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              bypass_i,
    output logic              level_o
);
    logic [1:0]       sync_q;
    logic [DIV_W-1:0] div_q;
    logic [3:0]       win_q;
    logic [3:0]       win_nxt;
    logic [2:0]       ones;
    logic             filt_q;
    logic             tick;

    assign tick    = (div_q >= rate_limit(rate_i));
    assign win_nxt = {win_q[2:0], sync_q[1]};
    assign ones    = ones4(win_nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            div_q  <= '0;
            win_q  <= '0;
            filt_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], pin_i};
            div_q  <= tick ? '0 : div_q + 1'b1;
            if (tick) begin
                win_q <= win_nxt;
                if (ones >= 3'd3)      filt_q <= 1'b1;
                else if (ones <= 3'd1) filt_q <= 1'b0;
            end
        end
    end

    assign level_o = bypass_i ? sync_q[1] : filt_q;

    assert_vote_high_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(filt_q) |-> ($countones(win_q) >= 3));

    assert_vote_low_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(filt_q) |-> ($countones(win_q) <= 1));

    assert_on_sample_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> $past(tick));
endmodule

// File: rtl/cap_channel.sv
module cap_channel
    import cap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_i,
    input  chan_cfg_t        cfg_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             clr_flag_i,
    input  logic             clr_ovr_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             flag_o,
    output logic             ovr_o
);
    logic             level;
    logic             prev_q;
    logic             hit;
    logic [CNT_W-1:0] cap_q;
    logic             flag_q;
    logic             ovr_q;

    cap_input_filter u_filt (
        .clk      (clk),
        .rst      (rst),
        .pin_i    (pin_i),
        .rate_i   (cfg_i.rate),
        .bypass_i (cfg_i.bypass),
        .level_o  (level)
    );

    always_comb begin
        case (cfg_i.edge_sel)
            EDGE_RISE: hit = level & ~prev_q;
            EDGE_FALL: hit = ~level & prev_q;
            EDGE_BOTH: hit = level ^ prev_q;
            default:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            cap_q  <= '0;
            flag_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            prev_q <= level;
            if (hit) cap_q <= cnt_i;
            if (clr_flag_i) flag_q <= 1'b0;
            if (hit)        flag_q <= 1'b1;
            if (clr_ovr_i)      ovr_q <= 1'b0;
            if (hit && flag_q)  ovr_q <= 1'b1;
        end
    end

    assign cap_o  = cap_q;
    assign flag_o = flag_q;
    assign ovr_o  = ovr_q;

    assert_stamp_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> (cap_q == $past(cnt_i)));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_flag_i) |=> flag_q);

    assert_overrun_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_q && hit) |=> ovr_q);

    assert_edge_off_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.edge_sel == EDGE_OFF) |=> $stable(cap_q));
endmodule

// File: rtl/cap_unit.sv
module cap_unit
    import cap_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = $clog2(2*NCH + 2),
    parameter int WD_W   = (CFG_W > 2*NCH + 1) ? CFG_W : 2*NCH + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    cap_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WD_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic [NCH-1:0]    cap_irq,
    output logic              wrap_irq
);
    localparam int STAT_ADDR = 2*NCH;
    localparam int CNT_ADDR  = 2*NCH + 1;
    localparam int WRAP_BIT  = 2*NCH;

    logic [CNT_W-1:0] cnt;
    logic             at_top;
    logic             wrap_q;
    logic             st_wr;
    chan_cfg_t        cfg_q   [NCH];
    logic [CNT_W-1:0] cap_val [NCH];
    logic [NCH-1:0]   flag;
    logic [NCH-1:0]   ovr;

    assign st_wr = wr_en && (wr_addr == ADDR_W'(STAT_ADDR));

    cap_free_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cnt_o    (cnt),
        .at_top_o (at_top)
    );

    always_ff @(posedge clk) begin
        if (rst) wrap_q <= 1'b0;
        else begin
            if (st_wr && wr_data[WRAP_BIT]) wrap_q <= 1'b0;
            if (at_top)                     wrap_q <= 1'b1;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) cfg_q[g] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(g)))
                cfg_q[g] <= chan_cfg_t'(wr_data[CFG_W-1:0]);
        end

        cap_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .pin_i      (cap_pin[g]),
            .cfg_i      (cfg_q[g]),
            .cnt_i      (cnt),
            .clr_flag_i (st_wr && wr_data[g]),
            .clr_ovr_i  (st_wr && wr_data[NCH+g]),
            .cap_o      (cap_val[g]),
            .flag_o     (flag[g]),
            .ovr_o      (ovr[g])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == ADDR_W'(i))       rd_data = CNT_W'(cfg_q[i]);
            if (rd_addr == ADDR_W'(NCH + i)) rd_data = cap_val[i];
        end
        if (rd_addr == ADDR_W'(STAT_ADDR)) rd_data = CNT_W'({wrap_q, ovr, flag});
        if (rd_addr == ADDR_W'(CNT_ADDR))  rd_data = cnt;
    end

    assign cap_irq  = flag;
    assign wrap_irq = wrap_q;

    assert_wrap_flag_R9: assert property (@(posedge clk) disable iff (rst)
        at_top |=> wrap_q);
endmodule

// File: tb/sim_cap_unit.sv
module sim_cap_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cap_pin = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [4:0]  wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [1:0]  cap_irq;
    logic        wrap_irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_unit u0 (
        .clk(clk), .rst(rst), .cap_pin(cap_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .cap_irq(cap_irq), .wrap_irq(wrap_irq)
    );

    // address map for two channels
    localparam logic [2:0] A_CTL0 = 3'd0, A_CTL1 = 3'd1, A_CAP0 = 3'd2,
                           A_CAP1 = 3'd3, A_STAT = 3'd4, A_CNT = 3'd5;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [4:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic pulse(input int ch, input int width);
        @(negedge clk);
        cap_pin[ch] = 1'b1;
        waitn(width);
        cap_pin[ch] = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        waitn(3);
        rd(A_STAT, v); chk(v == 16'h0, "R10 status", v, 0);
        rd(A_CNT, v);  chk(v == 16'h0, "R10 counter", v, 0);
        rd(A_CAP0, v); chk(v == 16'h0, "R10 cap0", v, 0);
        chk(cap_irq == 2'b00 && wrap_irq == 1'b0, "R10 irq", {cap_irq, wrap_irq}, 0);
        rst = 1'b0;
    endtask

    task automatic t_bypass;
        logic [15:0] c, v;
        wr(A_CTL0, 5'h0C);
        rd(A_CTL0, v); chk(v == 16'h000C, "R11 ctrl readback", v, 16'h0C);
        waitn(6);
        rd(A_CNT, c);
        cap_pin[0] = 1'b1;
        waitn(2);
        chk(cap_irq[0] == 1'b0, "R2 not before edge 3", cap_irq[0], 0);
        waitn(1);
        chk(cap_irq[0] == 1'b1, "R2 flag at edge 3", cap_irq[0], 1);
        rd(A_CAP0, v); chk(v == c + 16'd2, "R2 bypass stamp", v, c + 16'd2);
        waitn(5);
        chk(cap_irq[0] == 1'b1, "R7 flag sticky", cap_irq[0], 1);
        wr(A_STAT, 5'h01);
        rd(A_STAT, v); chk(v == 16'h0, "R7 write-one clear", v, 0);
        cap_pin[0] = 1'b0;
        waitn(6);
        chk(cap_irq[0] == 1'b0, "R6 falling ignored in rise mode", cap_irq[0], 0);
        rd(A_CAP0, v); chk(v == c + 16'd2, "R6 value kept", v, c + 16'd2);
        // bypass passes a two-clock pulse
        pulse(0, 2);
        waitn(4);
        chk(cap_irq[0] == 1'b1, "R5 short pulse seen in bypass", cap_irq[0], 1);
        wr(A_STAT, 5'h01);
    endtask

    task automatic t_filter_rate0;
        logic [15:0] c, v;
        wr(A_CTL0, 5'h08);
        waitn(6);
        pulse(0, 2);
        waitn(8);
        chk(cap_irq[0] == 1'b0, "R3 two-sample pulse rejected", cap_irq[0], 0);
        pulse(0, 3);
        waitn(8);
        chk(cap_irq[0] == 1'b1, "R3 three-sample pulse accepted", cap_irq[0], 1);
        wr(A_STAT, 5'h01);
        waitn(8);
        rd(A_CNT, c);
        cap_pin[0] = 1'b1;
        waitn(5);
        chk(cap_irq[0] == 1'b0, "R4 rate0 not early", cap_irq[0], 0);
        waitn(1);
        chk(cap_irq[0] == 1'b1, "R4 rate0 flag", cap_irq[0], 1);
        rd(A_CAP0, v); chk(v == c + 16'd5, "R4 rate0 stamp", v, c + 16'd5);
        wr(A_STAT, 5'h01);
        // both edges, level high: a two-sample low dip must hold the level
        wr(A_CTL0, 5'h18);
        waitn(4);
        @(negedge clk); cap_pin[0] = 1'b0;
        waitn(2);       cap_pin[0] = 1'b1;
        waitn(8);
        chk(cap_irq[0] == 1'b0, "R3 hold on two-two split", cap_irq[0], 0);
        cap_pin[0] = 1'b0;
        waitn(8);
        chk(cap_irq[0] == 1'b1, "R6 falling seen in both mode", cap_irq[0], 1);
        wr(A_STAT, 5'h01);
    endtask

    task automatic t_rates;
        logic [15:0] c, v;
        wr(A_CTL0, 5'h0B);
        waitn(40);
        pulse(0, 16);
        waitn(40);
        chk(cap_irq[0] == 1'b0, "R4 rate3 two-period pulse rejected", cap_irq[0], 0);
        rd(A_CNT, c);
        cap_pin[0] = 1'b1;
        waitn(40);
        rd(A_CAP0, v);
        chk(cap_irq[0] == 1'b1 && v >= c + 16'd19 && v <= c + 16'd26,
            "R4 rate3 stamp window", v - c, 19);
        cap_pin[0] = 1'b0;
        waitn(40);
        wr(A_CTL0, 5'h09);
        waitn(10);
        wr(A_STAT, 5'h01);
        rd(A_CNT, c);
        cap_pin[0] = 1'b1;
        waitn(12);
        rd(A_CAP0, v);
        chk(cap_irq[0] == 1'b1 && v >= c + 16'd7 && v <= c + 16'd8,
            "R4 rate1 stamp window", v - c, 7);
        cap_pin[0] = 1'b0;
        waitn(12);
        wr(A_STAT, 5'h01);
    endtask

    task automatic t_ch1;
        logic [15:0] c, v, keep0;
        rd(A_CAP0, keep0);
        wr(A_CTL1, 5'h14);
        waitn(6);
        cap_pin[1] = 1'b1;
        waitn(6);
        chk(cap_irq[1] == 1'b0, "R6 rising ignored in fall mode", cap_irq[1], 0);
        rd(A_CNT, c);
        cap_pin[1] = 1'b0;
        waitn(3);
        chk(cap_irq[1] == 1'b1, "R6 falling captured", cap_irq[1], 1);
        rd(A_CAP1, v); chk(v == c + 16'd2, "R2 ch1 stamp", v, c + 16'd2);
        chk(cap_irq[0] == 1'b0, "R1 ch0 flag untouched", cap_irq[0], 0);
        rd(A_CAP0, v); chk(v == keep0, "R1 ch0 value untouched", v, keep0);
        wr(A_STAT, 5'h02);
        wr(A_CTL1, 5'h1C);
        rd(A_CNT, c);
        cap_pin[1] = 1'b1;
        waitn(3);
        rd(A_CAP1, v); chk(v == c + 16'd2, "R6 both: rising captured", v, c + 16'd2);
        rd(A_CNT, c);
        cap_pin[1] = 1'b0;
        waitn(3);
        rd(A_STAT, v); chk(v == 16'h000A, "R8 overrun set", v, 16'h0A);
        rd(A_CAP1, v); chk(v == c + 16'd2, "R8 newer value kept", v, c + 16'd2);
        wr(A_STAT, 5'h0A);
        rd(A_STAT, v); chk(v == 16'h0, "R8 overrun cleared", v, 0);
        rd(A_CAP1, keep0);
        wr(A_CTL1, 5'h04);
        waitn(4);
        pulse(1, 6);
        waitn(6);
        rd(A_STAT, v); chk(v == 16'h0, "R6 edge off: no flag", v, 0);
        rd(A_CAP1, v); chk(v == keep0, "R6 edge off: value kept", v, keep0);
        rd(3'd6, v); chk(v == 16'h0, "R11 unmapped reads zero", v, 0);
    endtask

    task automatic t_wrap;
        logic [15:0] v, s;
        bit found = 0;
        for (int i = 0; i < 70000 && !found; i++) begin
            @(negedge clk);
            rd(A_CNT, v);
            if (v == 16'hFFFF) begin
                rd(A_STAT, s);
                chk(s[4] == 1'b0, "R9 no wrap flag before wrap", s[4], 0);
                @(negedge clk);
                rd(A_CNT, v);
                chk(v == 16'h0, "R9 counter wraps to zero", v, 0);
                rd(A_STAT, s);
                chk(s == 16'h0010 && wrap_irq, "R9 wrap flag set", s, 16'h10);
                found = 1;
            end
        end
        chk(found, "R9 wrap reached", found, 1);
        wr(A_STAT, 5'h10);
        rd(A_STAT, s); chk(s == 16'h0 && !wrap_irq, "R9 wrap flag cleared", s, 0);
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_filter_rate0();
        t_rates();
        t_ch1();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule